// File: doc/BRIEF.md
# Pipelined Carry-Save Tree Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the full product of `2*WIDTH` bits. It takes a new operand pair on every clock and returns each product after a fixed number of cycles. Products leave in the order their operands arrived. A one-bit valid qualifier travels with each pair.

Inside, all partial-product rows are formed at the same time and held in a register. A tree of 3:2 full-adder compressors then reduces them to two rows, one of sums and one of carries. No compressor level lets a carry travel further than one bit position, and every level ends in a register. The last pair of rows is registered and goes to a five-stage lookahead adder. That adder works on 4-bit blocks and 16-bit groups, so no stage ripples a carry across more than one short block or a handful of group steps. Each stage is kept to roughly one four-input function between registers.

A synchronous reset clears only the valid qualifiers. Data registers are not reset, so a pair that is in flight when reset arrives is dropped and produces no result.

Top module: `csa_tree_mult`

## Requirements
- R1: When `out_valid` is high, `out_product` equals the unsigned product `in_a * in_b` of the pair it belongs to. This holds for every operand pair.
- R2: The corner operands 0, 1 and all-ones give exact products: zero, the other operand, and 2^(2N) − 2^(N+1) + 1 for all-ones squared.
- R3: A pair presented with `in_valid` high before rising edge t appears on the outputs after rising edge t + LAT − 1. LAT = 6 + L, where L is the number of compressor levels. L counts the steps m → m − floor(m/3), starting from m = WIDTH, until two rows remain. This gives LAT = 12 for WIDTH 16 and LAT = 9 for WIDTH 5.
- R4: A new pair is accepted on every clock with no stall. Each accepted pair gives exactly one result, in order. No more than LAT pairs are in flight at once.
- R5: A cycle in which `in_valid` is low gives a cycle with `out_valid` low, LAT cycles later.
- R6: Reset is synchronous. `out_valid` is low after any edge at which `rst` is high. Pairs accepted in the LAT − 1 edges before a reset edge, or during reset, never produce a result.
- R7: Each compressor level outputs rows whose sum, modulo 2^(2N), equals the sum of its input rows one cycle earlier.
- R8: The final adder outputs the sum of its two input rows, modulo 2^(2N), exactly five cycles after they arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the valid pipeline |
| in_valid | input | 1 | Qualifies `in_a` and `in_b` in this cycle |
| in_a | input | WIDTH | Multiplicand, unsigned |
| in_b | input | WIDTH | Multiplier, unsigned |
| out_valid | output | 1 | High when `out_product` holds a result |
| out_product | output | 2*WIDTH | Full unsigned product |

## Verification
The hardest condition to reach from the ports is a reset that lands while the pipeline is full. The check must confirm that exactly the LAT most recent pairs disappear, while pairs accepted earlier still emerge correctly. The stimulus streams pairs back to back, raises reset for two cycles in the middle of the stream, and keeps presenting valid pairs during reset. The expected-result history then marks the affected window as dropped.

The other hard case is a carry that must cross every lookahead group at once. All-ones times all-ones causes this, and it is placed at the very start of a back-to-back stream. A narrow 5-bit instance is swept over all 1024 operand pairs, one per cycle, alongside the 16-bit instance.

// File: rtl/csa_tree_pkg.sv
package csa_tree_pkg;

  // register stages inside the final lookahead adder
  localparam int MERGE_STAGES = 5;

  // rows left after one 3:2 level: each triple becomes two rows, leftovers pass
  function automatic int rows_after_level(input int rows);
    return (rows / 3) * 2 + (rows % 3);
  endfunction

  // number of 3:2 levels needed to reach two rows
  function automatic int level_count(input int rows);
    int r;
    int n;
    r = rows;
    n = 0;
    while (r > 2) begin
      r = rows_after_level(r);
      n++;
    end
    return n;
  endfunction

  // row count entering level lvl
  function automatic int rows_at_level(input int rows, input int lvl);
    int r;
    r = rows;
    for (int i = 0; i < lvl; i++) r = rows_after_level(r);
    return r;
  endfunction

  // partial-product register + compressor levels + adder stages
  function automatic int pipe_latency(input int width);
    return 1 + level_count(width) + MERGE_STAGES;
  endfunction

  // generate/propagate of a 4-wide slice, packed as {G, P}
  function automatic logic [1:0] gp4(input logic [3:0] g, input logic [3:0] p);
    logic gg;
    gg = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0]);
    return {gg, &p};
  endfunction

endpackage

// File: rtl/csa_tree_ppgen.sv
module csa_tree_ppgen #(
  parameter int WIDTH = 16,
  localparam int PW = 2 * WIDTH
) (
  input  logic                  clk,
  input  logic [WIDTH-1:0]      op_a,
  input  logic [WIDTH-1:0]      op_b,
  output logic [WIDTH*PW-1:0]   rows_q
);

  logic [WIDTH*PW-1:0] rows_d;

  // row k is op_a shifted by k, gated by bit k of op_b
  for (genvar k = 0; k < WIDTH; k++) begin : g_row
    assign rows_d[k*PW +: PW] = op_b[k] ? (PW'(op_a) << k) : '0;
  end

  always_ff @(posedge clk) rows_q <= rows_d;

endmodule

// File: rtl/csa_tree_level.sv
module csa_tree_level #(
  parameter int PW      = 32,
  parameter int ROWS_IN = 16,
  localparam int ROWS_OUT = csa_tree_pkg::rows_after_level(ROWS_IN)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     vin,
  input  logic [ROWS_IN*PW-1:0]    rows_in,
  output logic [ROWS_OUT*PW-1:0]   rows_out
);

  localparam int TRIPLES = ROWS_IN / 3;
  localparam int LEFT    = ROWS_IN % 3;

  function automatic logic [PW-1:0] fa_sum(input logic [PW-1:0] x, input logic [PW-1:0] y,
                                           input logic [PW-1:0] z);
    return x ^ y ^ z;
  endfunction

  function automatic logic [PW-1:0] fa_carry(input logic [PW-1:0] x, input logic [PW-1:0] y,
                                             input logic [PW-1:0] z);
    return ((x & y) | (x & z) | (y & z)) << 1;
  endfunction

  logic [ROWS_OUT*PW-1:0] rows_nxt;

  for (genvar t = 0; t < TRIPLES; t++) begin : g_fa
    assign rows_nxt[(2*t)*PW +: PW]   = fa_sum(rows_in[(3*t)*PW +: PW],
                                               rows_in[(3*t+1)*PW +: PW],
                                               rows_in[(3*t+2)*PW +: PW]);
    assign rows_nxt[(2*t+1)*PW +: PW] = fa_carry(rows_in[(3*t)*PW +: PW],
                                                 rows_in[(3*t+1)*PW +: PW],
                                                 rows_in[(3*t+2)*PW +: PW]);
  end

  for (genvar r = 0; r < LEFT; r++) begin : g_pass
    assign rows_nxt[(2*TRIPLES+r)*PW +: PW] = rows_in[(3*TRIPLES+r)*PW +: PW];
  end

  always_ff @(posedge clk) rows_out <= rows_nxt;

  // row totals, brought out for the level check
  logic [PW-1:0] in_total;
  logic [PW-1:0] out_total;

  always_comb begin
    in_total = '0;
    for (int i = 0; i < ROWS_IN; i++) in_total = in_total + rows_in[i*PW +: PW];
  end

  always_comb begin
    out_total = '0;
    for (int i = 0; i < ROWS_OUT; i++) out_total = out_total + rows_out[i*PW +: PW];
  end

  AST_LEVEL_SUM_KEPT: assert property (@(posedge clk) disable iff (rst) $past(vin) |-> (out_total == $past(in_total))); // R7

endmodule

// File: rtl/csa_tree_merge.sv
module csa_tree_merge #(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vin,
  input  logic [W-1:0]  op_x,
  input  logic [W-1:0]  op_y,
  output logic [W-1:0]  sum_q
);
  import csa_tree_pkg::*;

  localparam int WP = ((W + 15) / 16) * 16;
  localparam int NB = WP / 4;
  localparam int NG = WP / 16;

  // stage 1: bit and block generate/propagate
  logic [WP-1:0] xe, ye, g0, p0;
  logic [NB-1:0] bg0, bp0;
  assign xe = WP'(op_x);
  assign ye = WP'(op_y);
  assign g0 = xe & ye;
  assign p0 = xe ^ ye;

  for (genvar b = 0; b < NB; b++) begin : g_blk
    assign {bg0[b], bp0[b]} = gp4(g0[4*b +: 4], p0[4*b +: 4]);
  end

  logic [WP-1:0] s1_g, s1_p;
  logic [NB-1:0] s1_bg, s1_bp;
  always_ff @(posedge clk) begin
    s1_g  <= g0;
    s1_p  <= p0;
    s1_bg <= bg0;
    s1_bp <= bp0;
  end

  // stage 2: group generate/propagate over four blocks
  logic [NG-1:0] gg1, gp1;
  for (genvar k = 0; k < NG; k++) begin : g_grp
    assign {gg1[k], gp1[k]} = gp4(s1_bg[4*k +: 4], s1_bp[4*k +: 4]);
  end

  logic [WP-1:0] s2_g, s2_p;
  logic [NB-1:0] s2_bg, s2_bp;
  logic [NG-1:0] s2_gg, s2_gp;
  always_ff @(posedge clk) begin
    s2_g  <= s1_g;
    s2_p  <= s1_p;
    s2_bg <= s1_bg;
    s2_bp <= s1_bp;
    s2_gg <= gg1;
    s2_gp <= gp1;
  end

  // stage 3: carry into each group
  logic [NG-1:0] gc2;
  always_comb begin
    logic c;
    c = 1'b0;
    for (int k = 0; k < NG; k++) begin
      gc2[k] = c;
      c = s2_gg[k] | (s2_gp[k] & c);
    end
  end

  logic [WP-1:0] s3_g, s3_p;
  logic [NB-1:0] s3_bg, s3_bp;
  logic [NG-1:0] s3_gc;
  always_ff @(posedge clk) begin
    s3_g  <= s2_g;
    s3_p  <= s2_p;
    s3_bg <= s2_bg;
    s3_bp <= s2_bp;
    s3_gc <= gc2;
  end

  // stage 4: carry into each block from its group carry
  logic [NB-1:0] bc3;
  always_comb begin
    logic c;
    for (int b = 0; b < NB; b++) begin
      c = s3_gc[b/4];
      for (int m = 0; m < b % 4; m++)
        c = s3_bg[(b/4)*4 + m] | (s3_bp[(b/4)*4 + m] & c);
      bc3[b] = c;
    end
  end

  logic [WP-1:0] s4_g, s4_p;
  logic [NB-1:0] s4_bc;
  always_ff @(posedge clk) begin
    s4_g  <= s3_g;
    s4_p  <= s3_p;
    s4_bc <= bc3;
  end

  // stage 5: bit carries inside each block, then the sum bits
  logic [W-1:0] sum5;
  always_comb begin
    logic c;
    for (int i = 0; i < W; i++) begin
      c = s4_bc[i/4];
      for (int m = 0; m < i % 4; m++)
        c = s4_g[(i/4)*4 + m] | (s4_p[(i/4)*4 + m] & c);
      sum5[i] = s4_p[i] ^ c;
    end
  end

  always_ff @(posedge clk) sum_q <= sum5;

  AST_MERGE_EXACT: assert property (@(posedge clk) disable iff (rst) $past(vin, 5) |-> (sum_q == $past(op_x + op_y, 5))); // R8

endmodule

// File: rtl/csa_tree_mult.sv
module csa_tree_mult #(
  parameter int WIDTH = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [WIDTH-1:0]      in_a,
  input  logic [WIDTH-1:0]      in_b,
  output logic                  out_valid,
  output logic [2*WIDTH-1:0]    out_product
);
  import csa_tree_pkg::*;

  localparam int PW     = 2 * WIDTH;
  localparam int LEVELS = level_count(WIDTH);
  localparam int LAT    = pipe_latency(WIDTH);
  localparam int CNT_W  = $clog2(LAT + 1) + 1;

  // valid qualifier, one bit per register stage
  logic [LAT-1:0] vpipe;
  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LAT-2:0], in_valid};
  end
  assign out_valid = vpipe[LAT-1];

  // rows between stages; level i drives entry i+1
  logic [WIDTH*PW-1:0] stage_rows [LEVELS+1];

  csa_tree_ppgen #(.WIDTH(WIDTH)) u_pp (
    .clk    (clk),
    .op_a   (in_a),
    .op_b   (in_b),
    .rows_q (stage_rows[0])
  );

  for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
    localparam int RI = rows_at_level(WIDTH, i);
    localparam int RO = rows_after_level(RI);
    logic [RO*PW-1:0] lvl_out;

    csa_tree_level #(.PW(PW), .ROWS_IN(RI)) u_lvl (
      .clk      (clk),
      .rst      (rst),
      .vin      (vpipe[i]),
      .rows_in  (stage_rows[i][RI*PW-1:0]),
      .rows_out (lvl_out)
    );

    assign stage_rows[i+1] = (WIDTH*PW)'(lvl_out);
  end

  csa_tree_merge #(.W(PW)) u_add (
    .clk   (clk),
    .rst   (rst),
    .vin   (vpipe[LEVELS]),
    .op_x  (stage_rows[LEVELS][PW-1:0]),
    .op_y  (stage_rows[LEVELS][2*PW-1:PW]),
    .sum_q (out_product)
  );

  // pairs accepted and not yet delivered
  logic [CNT_W-1:0] pending;
  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else     pending <= pending + CNT_W'(in_valid) - CNT_W'(out_valid);
  end

  AST_INFLIGHT_BOUND:   assert property (@(posedge clk) disable iff (rst) pending <= CNT_W'(LAT)); // R4
  AST_NO_ORPHAN_RESULT: assert property (@(posedge clk) disable iff (rst) out_valid |-> (pending != '0)); // R4
  AST_RESET_CLEARS:     assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> !out_valid); // R6

endmodule

// File: tb/sim_csa_tree_mult.sv
`timescale 1ns/1ps
module sim_csa_tree_mult;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        v0 = 1'b0, v1 = 1'b0;
  logic [15:0] a0 = '0, b0 = '0;
  logic [4:0]  a1 = '0, b1 = '0;
  logic        ov0, ov1;
  logic [31:0] pr0;
  logic [9:0]  pr1;

  csa_tree_mult #(.WIDTH(16)) u0 (
    .clk(clk), .rst(rst), .in_valid(v0), .in_a(a0), .in_b(b0),
    .out_valid(ov0), .out_product(pr0)
  );

  csa_tree_mult #(.WIDTH(5)) u1 (
    .clk(clk), .rst(rst), .in_valid(v1), .in_a(a1), .in_b(b1),
    .out_valid(ov1), .out_product(pr1)
  );

  // latency restated: rows shrink by a third (rounded down) per level
  function automatic int model_latency(input int n);
    int m;
    int l;
    m = n;
    l = 0;
    while (m > 2) begin
      m = m - m / 3;
      l++;
    end
    return l + 6;
  endfunction

  int LAT0, LAT1;
  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int since_rst = 0;
  bit done = 1'b0;

  bit          hv0 [64];
  bit          hc0 [64];
  logic [31:0] hp0 [64];
  bit          hv1 [64];
  logic [9:0]  hp1 [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock: check what is visible now, then drive the next inputs
  task automatic step(input bit r, input bit va, input logic [15:0] xa, input logic [15:0] xb,
                      input bit corner, input bit vb, input logic [4:0] ya, input logic [4:0] yb);
    int i0, i1;
    bit e0, e1;
    @(negedge clk);
    if (cyc > 0) begin
      i0 = (cyc - LAT0) & 63;
      i1 = (cyc - LAT1) & 63;
      e0 = (cyc >= LAT0) ? hv0[i0] : 1'b0;
      e1 = (cyc >= LAT1) ? hv1[i1] : 1'b0;
      if (e0) begin
        chk(ov0 === 1'b1, "R3", "u0 valid at latency", 64'(ov0), 64'd1);
        // R1 R2 product; also covers R7 R8 internally
        chk(pr0 === hp0[i0], hc0[i0] ? "R2" : "R1", "u0 product", 64'(pr0), 64'(hp0[i0]));
      end else begin
        chk(ov0 === 1'b0, (since_rst <= LAT0 + 1) ? "R6" : "R5", "u0 idle valid", 64'(ov0), 64'd0);
      end
      if (e1) begin
        chk(ov1 === 1'b1, "R3", "u1 valid at latency", 64'(ov1), 64'd1);
        chk(pr1 === hp1[i1], "R1", "u1 product", 64'(pr1), 64'(hp1[i1]));
      end else begin
        chk(ov1 === 1'b0, (since_rst <= LAT1 + 1) ? "R6" : "R5", "u1 idle valid", 64'(ov1), 64'd0);
      end
    end
    rst = r;
    v0 = va; a0 = xa; b0 = xb;
    v1 = vb; a1 = ya; b1 = yb;
    hv0[cyc & 63] = va && !r;
    hc0[cyc & 63] = corner;
    hp0[cyc & 63] = 32'(xa) * 32'(xb);
    hv1[cyc & 63] = vb && !r;
    hp1[cyc & 63] = 10'(ya) * 10'(yb);
    if (r) begin
      // R6: pairs still in flight at this reset edge are dropped
      for (int t = cyc - LAT0 + 1; t <= cyc; t++) if (t >= 0) hv0[t & 63] = 1'b0;
      for (int t = cyc - LAT1 + 1; t <= cyc; t++) if (t >= 0) hv1[t & 63] = 1'b0;
      since_rst = 0;
    end else begin
      since_rst++;
    end
    cyc++;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    logic [15:0] corners [3];
    corners[0] = 16'h0000;
    corners[1] = 16'h0001;
    corners[2] = 16'hFFFF;
    LAT0 = model_latency(16);
    LAT1 = model_latency(5);
    for (int i = 0; i < 64; i++) begin
      hv0[i] = 1'b0;
      hv1[i] = 1'b0;
      hc0[i] = 1'b0;
      hp0[i] = '0;
      hp1[i] = '0;
    end
    chk(LAT0 == 12 && LAT1 == 9, "R3", "latency model", 64'(LAT0), 64'd12);

    // reset state: R6
    for (int k = 0; k < 8; k++) step(1'b1, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);

    // R2 corners first (all-ones squared at the very start), then R1 random
    // with R5 gaps on u0; u1 swept over all pairs back to back (R1, R4)
    for (int k = 0; k < 1024; k++) begin
      logic [9:0] kk;
      kk = 10'(k);
      if (k < 9)
        step(1'b0, 1'b1, corners[2 - k/3], corners[2 - k%3], 1'b1, 1'b1, kk[9:5], kk[4:0]);
      else
        step(1'b0, (k % 7) != 3, 16'($urandom), 16'($urandom), 1'b0, 1'b1, kk[9:5], kk[4:0]);
    end
    for (int k = 0; k < 16; k++) step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);

    // R6: reset in the middle of a full pipeline, inputs kept valid during it
    for (int k = 0; k < 20; k++)
      step(1'b0, 1'b1, 16'($urandom), 16'($urandom), 1'b0, 1'b1, 5'($urandom), 5'($urandom));
    for (int k = 0; k < 2; k++)
      step(1'b1, 1'b1, 16'($urandom), 16'($urandom), 1'b0, 1'b1, 5'($urandom), 5'($urandom));
    for (int k = 0; k < 10; k++)
      step(1'b0, 1'b1, 16'($urandom), 16'($urandom), 1'b0, 1'b1, 5'($urandom), 5'($urandom));
    for (int k = 0; k < 16; k++) step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);

    // R3: a lone pair, result must appear at exactly the latency
    step(1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 5'h1F, 5'h1F);
    for (int k = 0; k < 16; k++) step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R4 watchdog: got %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

endmodule